// File: doc/BRIEF.md
# Debug Serial Port, System-Clock Synchronized

This block is the target end of a bit-serial link between an external debug host and an on-chip debug module. The host drives a serial clock and a serial data line, and both are asynchronous to the chip. The block runs entirely on the system clock. It passes both lines through a synchronizer chain and treats the serial clock as data. A serial clock level is accepted only after it has read the same on two consecutive system clock edges. Each accepted low-to-high transition is one serial strobe.

On every strobe one register takes the incoming bit at its low end and shifts its high bit out towards the host, so receive and transmit advance together, most significant bit first. After the last bit of a fixed-length packet, the received word is offered on a parallel port for one cycle. On the following clock edge the register is loaded with the reply the debug module supplies. If no reply is pending, a not-ready word with only its top bit set is loaded instead.

The controller has three states. ST_IDLE waits for the first strobe of a packet. ST_SHIFT collects the remaining bits. ST_DONE lasts one cycle, flags the packet and loads the reply. The transitions are:
- ST_IDLE→ST_SHIFT on the first strobe.
- ST_IDLE or ST_SHIFT→ST_DONE on the strobe that completes the packet.
- ST_DONE→ST_IDLE unconditionally.

Top module: `dbg_serial_port`

## Requirements
- R1: While reset is high and on the cycle after, the serial output is 0 and the receive-valid output is 0. Reset clears the synchronizers, the bit counter and the shift register.
- R2: A serial clock high that lasts only one system clock cycle is ignored. It neither shifts the register nor advances the bit counter, so the packet after such glitches is still received intact.
- R3: Each accepted rising edge of the serial clock does two things in the same clock edge: it takes the synchronized data bit into bit 0 of the shift register and moves the next bit to the serial output. Data is received most significant bit first.
- R4: The serial output comes straight from the top bit of the shift register. It stays constant while the serial clock has been low for the last four sampled cycles, except on the edge that loads a reply.
- R5: After the 17th accepted edge, the receive-valid output is high for exactly one cycle, with the 17 received bits on the packet output. Bit 16 is the first bit received.
- R6: On the edge that ends the valid cycle, with the reply-pending input high, the register loads the 17-bit reply word. The host then reads it most significant bit first during the next packet.
- R7: With the reply-pending input low at that edge, the register loads 0x10000, the not-ready word with only bit 16 set.
- R8: Transfers are correct at the fastest serial clock of 5 system clocks per bit (3 high, 2 low) and at slower rates.
- R9: The first packet after reset shifts out all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial clock from host |
| ser_din_i | input | 1 | Asynchronous serial data from host |
| ser_dout_o | output | 1 | Registered serial data to host |
| rx_data_o | output | PKT_W | Received packet, valid with rx_valid_o |
| rx_valid_o | output | 1 | One-cycle pulse when a packet completes |
| tx_data_i | input | PKT_W | Reply word for the next packet |
| tx_pending_i | input | 1 | Reply word is available |

## Verification
The bench builds the block with its defaults: a 17-bit packet and two synchronizer stages. With those values, a 5-cycle serial period leaves exactly one cycle of slack between an accepted edge and the next serial clock rise, which exercises the tightest timing the block must meet. Runs at 5 and 11 cycles per bit compare received packets and returned replies. Back-to-back packets alternate between pending replies and the not-ready word. Trains of one-cycle clock glitches are inserted before a packet, so any miscounted bit shows up as a misaligned packet.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } dsp_state_e;
endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dsp_edge_qual.sv
module dsp_edge_qual (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;
    logic held_q;
    logic agree;

    assign agree  = (lvl_i == prev_q);
    assign rise_o = agree && lvl_i && !held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            if (agree) held_q <= lvl_i;
        end
    end
endmodule

// File: rtl/dsp_shift.sv
module dsp_shift #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (load_en)  sr_q <= load_val;
        else if (shift_en) sr_q <= {sr_q[W-2:0], bit_in};
    end

    assign q_o = sr_q;
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
    import dsp_pkg::*;
#(
    parameter int PKT_W       = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_din_i,
    output logic             ser_dout_o,
    output logic [PKT_W-1:0] rx_data_o,
    output logic             rx_valid_o,
    input  logic [PKT_W-1:0] tx_data_i,
    input  logic             tx_pending_i
);
    localparam int CNT_W = $clog2(PKT_W + 1);
    localparam logic [PKT_W-1:0] NOT_READY = {1'b1, {(PKT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(PKT_W - 1);

    logic [1:0]       sync_q;
    logic             rise;
    logic             shift_en;
    logic             load_en;
    logic             last_bit;
    logic [CNT_W-1:0] cnt_q;
    logic [PKT_W-1:0] sr;
    dsp_state_e       state_q, state_d;

    dsp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({ser_clk_i, ser_din_i}),
        .q_o (sync_q)
    );

    dsp_edge_qual u_qual (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (sync_q[1]),
        .rise_o (rise)
    );

    dsp_shift #(.W(PKT_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .bit_in   (sync_q[0]),
        .load_en  (load_en),
        .load_val (tx_pending_i ? tx_data_i : NOT_READY),
        .q_o      (sr)
    );

    assign last_bit = (cnt_q == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rise) state_d = last_bit ? ST_DONE : ST_SHIFT;
            ST_SHIFT: if (rise && last_bit) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        shift_en   = 1'b0;
        load_en    = 1'b0;
        rx_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SHIFT: shift_en = rise;
            ST_DONE: begin
                rx_valid_o = 1'b1;
                load_en    = 1'b1;
            end
            default: ;
        endcase
    end

    // bit counter
    always_ff @(posedge clk) begin
        if (rst)                        cnt_q <= '0;
        else if (shift_en && last_bit)  cnt_q <= '0;
        else if (shift_en)              cnt_q <= cnt_q + 1'b1;
    end

    assign rx_data_o  = sr;
    assign ser_dout_o = sr[PKT_W-1];
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker #(
    parameter int PKT_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_clk_i,
    input logic             ser_dout_o,
    input logic             rx_valid_o,
    input logic [PKT_W-1:0] tx_data_i,
    input logic             tx_pending_i
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!ser_dout_o && !rx_valid_o));

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    // R3: a packet ends only after a serial clock high held two samples
    assert_edge_held_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> ($past(ser_clk_i, 3) && $past(ser_clk_i, 4)));

    assert_quiet_out_R4: assert property (@(posedge clk) disable iff (rst)
        (!ser_clk_i && !$past(ser_clk_i) && !$past(ser_clk_i, 2) &&
         !$past(ser_clk_i, 3) && !$past(rx_valid_o)) |-> $stable(ser_dout_o));

    assert_reply_load_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && tx_pending_i) |=> (ser_dout_o == $past(tx_data_i[PKT_W-1])));

    assert_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && !tx_pending_i) |=> ser_dout_o);
endmodule

bind dbg_serial_port dsp_checker #(.PKT_W(PKT_W)) u_dsp_checker (
    .clk          (clk),
    .rst          (rst),
    .ser_clk_i    (ser_clk_i),
    .ser_dout_o   (ser_dout_o),
    .rx_valid_o   (rx_valid_o),
    .tx_data_i    (tx_data_i),
    .tx_pending_i (tx_pending_i)
);

// File: tb/dbg_serial_port_bench.sv
module dbg_serial_port_bench;
    localparam int W = 17;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_clk = 1'b0;
    logic         ser_din = 1'b0;
    logic         ser_dout;
    logic [W-1:0] rx_data;
    logic         rx_valid;
    logic [W-1:0] tx_data = '0;
    logic         tx_pending = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_q [$];
    logic [W-1:0] next_reply = '0;

    always #5 clk = ~clk;

    dbg_serial_port u_dbg_serial_port (
        .clk          (clk),
        .rst          (rst),
        .ser_clk_i    (ser_clk),
        .ser_din_i    (ser_din),
        .ser_dout_o   (ser_dout),
        .rx_data_o    (rx_data),
        .rx_valid_o   (rx_valid),
        .tx_data_i    (tx_data),
        .tx_pending_i (tx_pending)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    // Monitor: pops expected packets as the design flags them (R5)
    int vlen = 0;
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            vlen++;
            if (vlen == 1) begin
                if (exp_q.size() == 0)
                    check(1'b0, "R5 unexpected packet", rx_data, '0);
                else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    check(rx_data == e, "R5 R3 packet", rx_data, e);
                end
            end else
                check(1'b0, "R5 valid longer than one cycle", W'(vlen), W'(1));
        end else vlen = 0;
    end

    // Driver: one packet, returns nothing; checks reply bits (R6 R7 R9)
    task automatic send_packet(input logic [W-1:0] cmd, input logic [W-1:0] reply,
                               input bit pend, input int hi, input int lo,
                               input string req);
        logic [W-1:0] got;
        logic [W-1:0] want;
        want = next_reply;
        exp_q.push_back(cmd);
        tx_data    = reply;
        tx_pending = pend;
        for (int i = W - 1; i >= 0; i--) begin
            ser_din = cmd[i];
            repeat (lo) @(negedge clk);
            got[i]  = ser_dout;
            ser_clk = 1'b1;
            repeat (hi) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (8) @(negedge clk);
        next_reply = pend ? reply : {1'b1, {(W-1){1'b0}}};
        check(got == want, req, got, want);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(ser_dout == 1'b0, "R1 dout in reset", W'(ser_dout), '0);
        check(rx_valid == 1'b0, "R1 valid in reset", W'(rx_valid), '0);
        rst = 1'b0;
        @(negedge clk);
        check(ser_dout == 1'b0 && rx_valid == 1'b0, "R1 after reset",
              W'({rx_valid, ser_dout}), '0);
        // fastest rate
        send_packet(17'h1A5C3, 17'h0F0F1, 1'b1, 3, 2, "R9 zeros after reset R8");
        send_packet(17'h00001, 17'h15555, 1'b1, 3, 2, "R6 reply pending R8");
        send_packet(17'h10000, 17'h0AAAA, 1'b0, 3, 2, "R6 second reply");
        send_packet(17'h1FFFF, 17'h12345, 1'b1, 3, 2, "R7 not ready word");
        // slower rate
        send_packet(17'h0AAAA, 17'h00001, 1'b1, 6, 5, "R6 reply slow R8");
        send_packet(17'h15555, 17'h1FFFF, 1'b1, 6, 5, "R6 reply slow again R8");
        // glitch trains then a packet (R2)
        for (int g = 0; g < 5; g++) begin
            ser_clk = 1'b1;
            @(negedge clk);
            ser_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        check(ser_dout == next_reply[W-1], "R2 R4 dout after glitches",
              W'(ser_dout), W'(next_reply[W-1]));
        send_packet(17'h0C3A5, 17'h00F00, 1'b0, 3, 2, "R2 reply after glitches");
        send_packet(17'h13579, 17'h00000, 1'b1, 3, 2, "R7 not ready after glitch");
        send_packet(17'h00000, 17'h00000, 1'b1, 4, 3, "R6 zero reply");
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R5 all packets flagged", W'(exp_q.size()), '0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule